// File: doc/BRIEF.md
# Dynamic RAM refresh and access controller

This block sits between a processor and a bank-organised array of dynamic RAM devices that together hold 16K bytes. It keeps the array alive by issuing one refresh cycle from a free-running interval timer, stepping a 6-bit row counter through all 64 rows. It also turns processor reads and writes into timed device cycles on the correct bank. All banks share one address bus, one active-low chip-select line and one active-low write strobe. Each bank has its own active-high clock-enable line.

A refresh cycle raises every bank's enable together, puts the row number on the low address lines and keeps the shared select inactive, so no device can take in data. A processor access raises only the enable of the decoded bank and drives select low. The processor holds its request until a one-clock ready pulse ends the access. A refresh that is due wins the next free slot, so an access can be delayed by at most one refresh cycle. All cycle lengths are parameters counted in clocks. The defaults are sized for a 200 MHz clock: a 400 ns cycle with a 230 ns enable pulse, and one row every 30 µs.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset every enable is low, select and write strobe are high (inactive), ready is low, and the first refresh uses row 0.
- R2: Refresh cycles start no more than REF_CLKS+CYC_CLKS+1 clocks apart, so each of the 64 rows is refreshed within 64 times that span.
- R3: A refresh cycle drives all bank enables high together for exactly CE_CLKS clocks, with select and write strobe high and the upper address bits zero.
- R4: An access drives only the enable of the bank given by cpu_addr[13:12], for exactly CE_CLKS clocks, with mem_addr equal to cpu_addr[11:0] and select low.
- R5: The write strobe goes low only on a write access, during exactly its CE_CLKS enable clocks, and never on a read.
- R6: The refresh row on mem_addr[5:0] rises by one after each refresh and wraps from 63 to 0.
- R7: cpu_ready is a single-clock pulse in the last clock of an access cycle and is never high during a refresh.
- R8: A pending refresh is served before a waiting access, and a refresh never waits for more than one access cycle. The latency from request to ready is therefore at most 2*CYC_CLKS+1 clocks.
- R9: Outside a cycle's enable window, all bank enables stay low.
- R10: Refresh cycles leave the stored data unchanged: data written before a full refresh pass reads back intact after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address; top bits select the bank |
| cpu_ready | output | 1 | One-clock pulse when the access completes |
| mem_addr | output | ADDR_W-BANK_W | Shared device address (row in low 6 bits) |
| mem_ce | output | BANKS | Per-bank enable, active high |
| mem_cs_n | output | 1 | Shared chip select, active low |
| mem_we_n | output | 1 | Shared write strobe, active low |

## Verification
A row counter that skips or repeats a value shows up on mem_addr at the next refresh, which comes within one timer interval. A stuck pending flag shows up as refresh gaps that are too long, or as accesses that never complete. A wrong bank decode or a select line left active during refresh shows up within the same cycle as an enable pattern that is not one-hot. It also shows up one refresh pass later as corrupted read-back data.

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ADDR_W   = 14,
  parameter int ROW_W    = 6,
  parameter int BANKS    = 4,
  parameter int CYC_CLKS = 80,
  parameter int CE_CLKS  = 46,
  parameter int REF_CLKS = 6000,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int DEV_W   = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [DEV_W-1:0]  mem_addr,
  output logic [BANKS-1:0]  mem_ce,
  output logic              mem_cs_n,
  output logic              mem_we_n
);
  localparam int CNT_W = $clog2(CYC_CLKS);
  localparam int TMR_W = $clog2(REF_CLKS);

  typedef enum logic [1:0] {IDLE, REFR, ACC} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [TMR_W-1:0]  tmr;
  logic              pend;
  logic [ROW_W-1:0]  row;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_we;

  wire tmr_wrap = (tmr == TMR_W'(REF_CLKS - 1));
  wire last     = (cnt == CNT_W'(CYC_CLKS - 1));
  wire ce_on    = (st != IDLE) && (cnt < CNT_W'(CE_CLKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      tmr      <= '0;
      pend     <= 1'b0;
      row      <= '0;
      acc_addr <= '0;
      acc_we   <= 1'b0;
    end else begin
      tmr  <= tmr_wrap ? '0 : tmr + 1'b1;
      pend <= tmr_wrap | (pend & (st != IDLE));
      case (st)
        IDLE: begin
          cnt <= '0;
          if (pend) st <= REFR;
          else if (cpu_req) begin
            st       <= ACC;
            acc_addr <= cpu_addr;
            acc_we   <= cpu_we;
          end
        end
        default: begin
          if (last) begin
            cnt <= '0;
            st  <= IDLE;
            if (st == REFR) row <= row + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_ce
    assign mem_ce[b] = ce_on && (st == REFR || acc_addr[ADDR_W-1 -: BANK_W] == BANK_W'(b));
  end

  assign mem_cs_n  = (st != ACC);
  assign mem_we_n  = !(st == ACC && acc_we && ce_on);
  assign mem_addr  = (st == REFR) ? DEV_W'(row) : acc_addr[DEV_W-1:0];
  assign cpu_ready = (st == ACC) && last;

  int pend_wait;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_wait <= 0;
    else        pend_wait <= (pend && st != REFR) ? pend_wait + 1 : 0;

  a_r8_refresh_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wait <= CYC_CLKS + 1);
  a_r3_refresh_keeps_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mem_ce) > 1) |-> (mem_cs_n && mem_we_n));
  a_r4_access_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> $onehot0(mem_ce));
  a_r5_strobe_needs_selected_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_ce != '0));
  a_r6_row_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (st == REFR && last) |=> (row == $past(row) + 1'b1));
  a_r7_ready_only_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (!mem_cs_n && !cpu_ready_d));

  logic cpu_ready_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cpu_ready_d <= 1'b0;
    else        cpu_ready_d <= cpu_ready;
endmodule

// File: tb/test_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module test_dram_refresh_ctrl;
  localparam int CYC = 8, CEW = 5, INTV = 60;
  localparam int GAP = INTV + CYC + 1;
  localparam int WIN = 64 * GAP;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [13:0] cpu_addr = '0;
  logic cpu_ready;
  logic [11:0] mem_addr;
  logic [3:0] mem_ce;
  logic mem_cs_n, mem_we_n;

  dram_refresh_ctrl #(.CYC_CLKS(CYC), .CE_CLKS(CEW), .REF_CLKS(INTV)) i_dram_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .mem_addr(mem_addr), .mem_ce(mem_ce),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  logic [7:0] store [int];
  logic [7:0] golden [int];
  logic [7:0] wdata = '0, rdata = '0;

  function automatic int bank_of(input logic [3:0] ce);
    for (int b = 0; b < 4; b++) if (ce[b]) return b;
    return 0;
  endfunction

  bit prev_all = 0, seen_ref = 0;
  int ref_ce = 0, last_ref = 0, n_ref = 0;
  int exp_row = 0;
  int row_last [64];
  initial foreach (row_last[r]) row_last[r] = 0;

  always @(negedge clk) if (rst_n) begin
    if (!mem_cs_n && mem_ce != 0) begin
      if (!mem_we_n) store[{bank_of(mem_ce), mem_addr}] = wdata;
      else if (store.exists({bank_of(mem_ce), mem_addr})) rdata = store[{bank_of(mem_ce), mem_addr}];
    end
    if (&mem_ce) begin
      if (!prev_all) begin
        chk(mem_cs_n && mem_we_n && mem_addr[11:6] == 0, "R3 refresh deselect", {mem_cs_n, mem_we_n}, 3);
        chk(mem_addr[5:0] == exp_row[5:0], "R6 row sequence", mem_addr[5:0], exp_row % 64);
        chk(cyc - last_ref <= GAP, "R2 refresh gap", cyc - last_ref, GAP);
        chk(cyc - row_last[mem_addr[5:0]] <= WIN, "R2 row window", cyc - row_last[mem_addr[5:0]], WIN);
        row_last[mem_addr[5:0]] = cyc;
        last_ref = cyc;
        exp_row = (exp_row + 1) % 64;
        n_ref++;
        ref_ce = 0;
      end
      ref_ce++;
    end else if (prev_all) chk(ref_ce == CEW, "R3 refresh CE width", ref_ce, CEW);
    prev_all = &mem_ce;
    if (mem_ce != 0 && !(&mem_ce))
      chk(!mem_cs_n && $onehot(mem_ce), "R9 enable pattern", mem_ce, 0);
    if (mem_cs_n && !(&mem_ce))
      chk(mem_ce == 0, "R9 idle enables", mem_ce, 0);
    if (cpu_ready) chk(!mem_cs_n && !(&mem_ce), "R7 ready outside refresh", mem_cs_n, 0);
  end

  int delayed = 0;
  task automatic access(input logic [13:0] a, input bit w, input logic [7:0] d);
    int lat = 0, ce_n = 0, we_c = 0, rdy_n = 0;
    bit addr_ok = 1;
    @(negedge clk);
    cpu_addr = a; cpu_we = w; wdata = d; cpu_req = 1;
    forever begin
      @(negedge clk);
      lat++;
      if (!mem_cs_n && mem_ce != 0) begin
        ce_n++;
        if (mem_ce != (4'b1 << a[13:12]) || mem_addr != a[11:0]) addr_ok = 0;
      end
      if (!mem_we_n) we_c++;
      if (cpu_ready) break;
      if (lat > 1000) break;
    end
    cpu_req = 0;
    chk(addr_ok, "R4 bank decode and address", a, a);
    chk(ce_n == CEW, "R4 access CE width", ce_n, CEW);
    chk(we_c == (w ? CEW : 0), "R5 write strobe", we_c, w ? CEW : 0);
    chk(lat <= 2 * CYC + 1 && lat >= CYC, "R8 access latency", lat, 2 * CYC + 1);
    if (lat > CYC) delayed++;
    @(negedge clk);
    chk(!cpu_ready, "R7 ready single pulse", cpu_ready, 0);
    if (w) golden[a] = d;
    else chk(golden.exists(a) && rdata == golden[a], "R10 data retained", rdata, golden.exists(a) ? golden[a] : -1);
  endtask

  function automatic logic [13:0] addr_of(input int b, input int i);
    return {b[1:0], 12'((i * 61 + b * 7) % 4096)};
  endfunction

  initial begin
    #1;
    chk(mem_ce == 0 && mem_cs_n && mem_we_n && !cpu_ready, "R1 reset outputs", mem_ce, 0);
    repeat (3) @(negedge clk);
    chk(mem_ce == 0 && mem_cs_n && mem_we_n && !cpu_ready, "R1 outputs in reset", mem_ce, 0);
    rst_n = 1;
    last_ref = cyc;
    foreach (row_last[r]) row_last[r] = cyc;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 64; i++)
        access(addr_of(b, i), 1, 8'((b * 64 + i) * 37 + 5));
    repeat (WIN + 100) @(negedge clk);
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 64; i++)
        access(addr_of(b, i), 0, 8'h00);
    chk(n_ref > 64, "R6 row counter wrapped", n_ref, 65);
    chk(delayed > 0, "R8 refresh served first", delayed, 1);
    for (int r = 0; r < 64; r++)
      chk(cyc - row_last[r] <= WIN, "R2 final row window", cyc - row_last[r], WIN);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule